// File: doc/BRIEF.md
# Memory-Mapped Load/Store Address Decoder

This block sits on the data-access port of a small processor. It classifies every load or store by its 32-bit byte address and sends it to one of two targets. The first target is a word-organised RAM with a synchronous read. The second is a UART that exposes three registers inside an I/O window. The block drives the RAM word address, the byte write enables and the write data. It also issues the one-cycle handshake strobes that take a received byte from the UART or hand it a byte to send. Read data comes back one cycle after the load, for both targets. In that cycle the block picks the RAM output or the UART value it captured at the time of the load.

The address space has two windows. An access is an I/O access only when the upper nibble is exactly 0x8. An access is a RAM access whenever bit 28 is set, whatever the other upper-nibble bits are. The two windows never overlap, because 0x8 has bit 28 clear. Inside the I/O window, the low address byte picks the UART function. Both UART sides use valid/ready. A byte moves only in a cycle where both valid and ready are high, and the decoder never waits. Software is expected to poll the status register before it pops or pushes a byte. A strobe raised while the other side is not ready simply transfers nothing, and there is no back-pressure on the processor.

Top module: `mmio_decoder`

## Requirements
- R1: `tx_valid` and `rx_ready` can only be high in a cycle whose access address has bits [31:28] equal to 4'b1000. Any other upper nibble raises neither strobe.
- R2: A store whose address has bit 28 set drives `ram_we` with the store's 4-bit byte mask in that same cycle, for any upper nibble that has bit 28 set. In every other cycle `ram_we` is 0.
- R3: `ram_addr` always equals byte-address bits [13:2], and `ram_wdata` always equals the store data.
- R4: A load from I/O offset 0x00 returns, in the following cycle, `rd_data` = {30 zero bits, rx_valid, tx_ready}. Bit 1 is `rx_valid` and bit 0 is `tx_ready`, both sampled in the load cycle.
- R5: A load from I/O offset 0x04 raises `rx_ready` for that one cycle. In the following cycle it returns `rd_data` = {24 zero bits, rx_data sampled in the load cycle}.
- R6: A store to I/O offset 0x08 raises `tx_valid` for that one cycle, with `tx_data` equal to store-data bits [7:0].
- R7: A load whose address has bit 28 set returns, in the following cycle, the `ram_rdata` the RAM presents in that cycle.
- R8: The following are ignored: an I/O access at any other offset, a store to offset 0x00 or 0x04, a load from offset 0x08, an address in neither window, and a cycle with no access. Ignored means no strobe and no RAM write enable, and `rd_data` is 0 in the following cycle.
- R9: While reset is held, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | A load or store is presented this cycle |
| acc_we | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Byte address |
| acc_wdata | input | 32 | Store data |
| acc_wmask | input | 4 | Byte mask for stores |
| rd_data | output | 32 | Load result, one cycle after the load |
| ram_addr | output | 12 | RAM word address |
| ram_we | output | 4 | RAM byte write enables |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after the address |
| rx_valid | input | 1 | UART holds a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Pop strobe for the received byte |
| tx_ready | input | 1 | UART can accept a byte |
| tx_valid | output | 1 | Push strobe for the byte to send |
| tx_data | output | 8 | Byte to send |

## Verification
Random 32-bit addresses almost never land on the I/O nibble with an exact function offset. They also rarely produce the near-miss nibbles such as 0x9 or 0xB, which set bit 28 but not the I/O pattern. The stimulus therefore draws the upper nibble from a short list of these cases and the low byte mostly from the three function offsets, and it pairs each offset with the wrong direction as often as the right one. `ram_rdata` changes every cycle. This shows that a load result follows the previous cycle's decode and the current RAM output, not a stale value.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  typedef enum logic [1:0] {SRC_NONE, SRC_RAM, SRC_IO} rd_src_e;
  typedef enum logic [1:0] {IO_NONE, IO_STAT, IO_RXD, IO_TXD} io_fn_e;

  localparam logic [3:0] IO_NIBBLE = 4'h8;
  localparam logic [7:0] OFF_STAT  = 8'h00;
  localparam logic [7:0] OFF_RXD   = 8'h04;
  localparam logic [7:0] OFF_TXD   = 8'h08;
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
  import mmio_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_hit,
  output io_fn_e            io_fn
);
  localparam int NIB_LSB = ADDR_W - 4;

  logic io_hit;
  logic [7:0] offset;

  assign mem_hit = en && addr[NIB_LSB];
  assign io_hit  = en && (addr[ADDR_W-1:NIB_LSB] == IO_NIBBLE);
  assign offset  = addr[7:0];

  always_comb begin
    io_fn = IO_NONE;
    if (io_hit) begin
      unique case (offset)
        OFF_STAT: if (!we) io_fn = IO_STAT;
        OFF_RXD:  if (!we) io_fn = IO_RXD;
        OFF_TXD:  if (we)  io_fn = IO_TXD;
        default:  io_fn = IO_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mmio_uart_port.sv
module mmio_uart_port
  import mmio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  io_fn_e            io_fn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              tx_ready,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic [DATA_W-1:0] io_rval
);
  assign rx_ready = (io_fn == IO_RXD);
  assign tx_valid = (io_fn == IO_TXD);
  assign tx_data  = wdata[BYTE_W-1:0];

  always_comb begin
    io_rval = '0;
    if (io_fn == IO_STAT) begin
      io_rval[1] = rx_valid;
      io_rval[0] = tx_ready;
    end else if (io_fn == IO_RXD) begin
      io_rval[BYTE_W-1:0] = rx_data;
    end
  end
endmodule

// File: rtl/mmio_rd_mux.sv
module mmio_rd_mux
  import mmio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_src_e           src_d,
  input  logic [DATA_W-1:0] io_rval_d,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] rd_data
);
  rd_src_e           src_q;
  logic [DATA_W-1:0] io_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= SRC_NONE;
      io_q  <= '0;
    end else begin
      src_q <= src_d;
      io_q  <= io_rval_d;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_RAM: rd_data = ram_rdata;
      SRC_IO:  rd_data = io_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/mmio_decoder.sv
module mmio_decoder
  import mmio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RAM_AW = 12,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_en,
  input  logic                acc_we,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [DATA_W-1:0]   acc_wdata,
  input  logic [DATA_W/8-1:0] acc_wmask,
  output logic [DATA_W-1:0]   rd_data,
  output logic [RAM_AW-1:0]   ram_addr,
  output logic [DATA_W/8-1:0] ram_we,
  output logic [DATA_W-1:0]   ram_wdata,
  input  logic [DATA_W-1:0]   ram_rdata,
  input  logic                rx_valid,
  input  logic [BYTE_W-1:0]   rx_data,
  output logic                rx_ready,
  input  logic                tx_ready,
  output logic                tx_valid,
  output logic [BYTE_W-1:0]   tx_data
);
  localparam int LANES    = DATA_W / 8;
  localparam int WORD_LSB = $clog2(LANES);

  logic              mem_hit;
  io_fn_e            io_fn;
  logic [DATA_W-1:0] io_rval;
  rd_src_e           src_d;

  mmio_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
    .en(acc_en), .we(acc_we), .addr(acc_addr),
    .mem_hit(mem_hit), .io_fn(io_fn)
  );

  mmio_uart_port #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) uart_i (
    .io_fn(io_fn), .wdata(acc_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_ready(tx_ready),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .io_rval(io_rval)
  );

  always_comb begin
    if (mem_hit && !acc_we)                      src_d = SRC_RAM;
    else if (io_fn == IO_STAT || io_fn == IO_RXD) src_d = SRC_IO;
    else                                          src_d = SRC_NONE;
  end

  assign ram_addr  = acc_addr[RAM_AW+WORD_LSB-1:WORD_LSB];
  assign ram_wdata = acc_wdata;
  assign ram_we    = (mem_hit && acc_we) ? acc_wmask : '0;

  mmio_rd_mux #(.DATA_W(DATA_W)) mux_i (
    .clk(clk), .rst_n(rst_n), .src_d(src_d), .io_rval_d(io_rval),
    .ram_rdata(ram_rdata), .rd_data(rd_data)
  );
endmodule

// File: rtl/mmio_decoder_chk.sv
module mmio_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_en,
  input logic        acc_we,
  input logic [31:0] acc_addr,
  input logic [31:0] acc_wdata,
  input logic [31:0] rd_data,
  input logic [3:0]  ram_we,
  input logic [31:0] ram_rdata,
  input logic        rx_valid,
  input logic [7:0]  rx_data,
  input logic        rx_ready,
  input logic        tx_ready,
  input logic        tx_valid,
  input logic [7:0]  tx_data
);
  assert_strobe_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || rx_ready) |-> acc_addr[31:28] == 4'b1000);

  assert_ram_we_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we != 4'h0) |-> (acc_en && acc_we && acc_addr[28]));

  assert_status_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && acc_addr[31:28] == 4'b1000 && acc_addr[7:0] == 8'h00)
    |=> rd_data == {30'b0, $past(rx_valid), $past(tx_ready)});

  assert_rx_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> rd_data == {24'b0, $past(rx_data)});

  assert_tx_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (acc_we && !rx_ready && tx_data == acc_wdata[7:0]));

  assert_ram_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && acc_addr[28]) |=> rd_data == ram_rdata);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (ram_we == 4'h0 && !tx_valid && !rx_ready));
endmodule

bind mmio_decoder mmio_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
  .ram_we(ram_we), .ram_rdata(ram_rdata), .rx_valid(rx_valid),
  .rx_data(rx_data), .rx_ready(rx_ready), .tx_ready(tx_ready),
  .tx_valid(tx_valid), .tx_data(tx_data)
);

// File: tb/mmio_decoder_tb_top.sv
`timescale 1ns/1ps
module mmio_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en, acc_we;
  logic [31:0] acc_addr, acc_wdata;
  logic [3:0]  acc_wmask;
  logic [31:0] rd_data;
  logic [11:0] ram_addr;
  logic [3:0]  ram_we;
  logic [31:0] ram_wdata, ram_rdata;
  logic        rx_valid, rx_ready, tx_ready, tx_valid;
  logic [7:0]  rx_data, tx_data;

  int total = 0;
  int bad   = 0;
  int prev_kind = 0;          // 0 none, 1 ram, 2 io
  logic [31:0] prev_io = '0;

  always #10 clk = ~clk;

  mmio_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_wmask(acc_wmask),
    .rd_data(rd_data), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_io(input logic [31:0] a);
    return a[31:28] == 4'b1000;
  endfunction

  task automatic step(input bit en, input bit we, input logic [31:0] addr,
                      input logic [31:0] wd, input logic [3:0] mask,
                      input bit rxv, input logic [7:0] rxd, input bit txr,
                      input logic [31:0] ramr);
    bit exp_rx, exp_tx, ld, st;
    logic [3:0]  exp_we;
    logic [31:0] exp_rd;
    @(negedge clk);
    acc_en = en; acc_we = we; acc_addr = addr; acc_wdata = wd; acc_wmask = mask;
    rx_valid = rxv; rx_data = rxd; tx_ready = txr; ram_rdata = ramr;
    #1;
    // result of the previous access (R4, R5, R7, R8)
    exp_rd = (prev_kind == 1) ? ramr : (prev_kind == 2) ? prev_io : 32'h0;
    check(rd_data == exp_rd, "R4/R5/R7/R8 rd_data", rd_data, exp_rd);
    ld = en && !we; st = en && we;
    exp_we = (st && addr[28]) ? mask : 4'h0;
    exp_rx = ld && is_io(addr) && addr[7:0] == 8'h04;
    exp_tx = st && is_io(addr) && addr[7:0] == 8'h08;
    check(ram_we == exp_we, "R2 ram_we", {28'b0, ram_we}, {28'b0, exp_we});
    check(ram_addr == addr[13:2] && ram_wdata == wd, "R3 ram_addr",
          {20'b0, ram_addr}, {20'b0, addr[13:2]});
    check(rx_ready == exp_rx, "R5/R1 rx_ready", {31'b0, rx_ready}, {31'b0, exp_rx});
    check(tx_valid == exp_tx, "R6/R1 tx_valid", {31'b0, tx_valid}, {31'b0, exp_tx});
    if (exp_tx) check(tx_data == wd[7:0], "R6 tx_data", {24'b0, tx_data}, {24'b0, wd[7:0]});
    // next expectation
    if (ld && addr[28]) begin
      prev_kind = 1;
    end else if (ld && is_io(addr) && addr[7:0] == 8'h00) begin
      prev_kind = 2; prev_io = {30'b0, rxv, txr};
    end else if (exp_rx) begin
      prev_kind = 2; prev_io = {24'b0, rxd};
    end else begin
      prev_kind = 0;
    end
  endtask

  function automatic logic [31:0] pick_addr();
    logic [3:0] nibs [6] = '{4'h8, 4'h9, 4'h1, 4'h0, 4'hB, 4'h3};
    logic [31:0] a = $urandom;
    int s = $urandom_range(0, 6);
    int o = $urandom_range(0, 4);
    if (s < 6) a[31:28] = nibs[s];
    if (o == 0) a[7:0] = 8'h00;
    else if (o == 1) a[7:0] = 8'h04;
    else if (o == 2) a[7:0] = 8'h08;
    return a;
  endfunction

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; acc_en = 0; acc_we = 0; acc_addr = '0; acc_wdata = '0;
    acc_wmask = '0; ram_rdata = 32'hDEAD_BEEF; rx_valid = 1; rx_data = 8'h5A;
    tx_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rd_data == 32'h0, "R9 reset rd_data", rd_data, 32'h0);
    rst_n = 1'b1;
    // directed corners
    step(1, 0, 32'h8000_0000, 0, 0, 1, 8'hA5, 0, 32'h1111_1111); // R4 status
    step(1, 0, 32'h8ABC_DE04, 0, 0, 1, 8'hC3, 1, 32'h2222_2222); // R5 pop
    step(1, 1, 32'h8000_0008, 32'h1234_5677, 4'hF, 0, 0, 1, 32'h3333_3333); // R6
    step(1, 0, 32'h1000_0010, 0, 0, 0, 0, 0, 32'h4444_4444); // R7 load
    step(0, 0, 32'h0, 0, 0, 0, 0, 0, 32'hCAFE_F00D);         // R7 result
    step(1, 1, 32'h9000_3FFC, 32'hFFFF_0000, 4'h3, 0, 0, 0, 32'h0); // R2 nibble 9
    step(1, 0, 32'h9000_0004, 0, 0, 1, 8'h77, 1, 32'h5555_5555); // R1 not I/O
    step(1, 1, 32'h8000_0004, 32'hFF, 4'hF, 1, 8'h11, 1, 32'h6666_6666); // R8 store rx
    step(1, 0, 32'h8000_0008, 0, 0, 1, 8'h22, 1, 32'h7777_7777); // R8 load tx
    step(1, 0, 32'h8000_000C, 0, 0, 1, 8'h33, 1, 32'h8888_8888); // R8 bad offset
    step(1, 0, 32'h2000_0000, 0, 0, 1, 8'h44, 1, 32'h9999_9999); // R8 no window
    step(0, 0, 32'h0, 0, 0, 0, 0, 0, 32'hAAAA_AAAA);
    // constrained random
    for (int i = 0; i < 2000; i++) begin
      step($urandom_range(0, 7) != 0, $urandom_range(0, 1), pick_addr(), $urandom,
           4'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), $urandom);
    end
    step(0, 0, 32'h0, 0, 0, 0, 0, 0, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule